// File: doc/BRIEF.md
# Escape-Time Fractal Iteration Engine

This block works out how many steps a point of the complex plane survives under the recurrence z ← z² + c before its squared magnitude crosses an escape threshold. The result is the escape-time count that a renderer turns into a colour. All arithmetic is signed fixed point with 28 fractional bits and 4 integer bits (Q4.28). Each iteration takes one clock cycle and needs three products: x·x, y·y and x·y. The two squares feed both the next value of z and the magnitude test.

The caller gives a pixel row and column, an origin for each axis and a step size, which is the reciprocal of the zoom. The engine maps the pixel onto the plane itself. In Julia mode the mapped point is the starting z and the constant c comes from two inputs. In Mandelbrot mode the mapped point is both the starting z and c. A one-cycle start strobe launches a run while the engine is idle. When the run ends, a one-cycle done pulse marks the count, and the count then stays on its output until the next run finishes.

Top module: `fe_engine`

## Requirements
- R1: While reset is asserted and after it is released, busy_o, done_o and count_o are all 0.
- R2: start_i is accepted only when busy_o is low. A start strobe seen while a run is in progress has no effect on that run's count or timing.
- R3: The real part of the start point is (row_i − org_row_i)·step_i and the imaginary part is (col_i − org_col_i)·step_i. Indices are unsigned, step_i is Q4.28, and each product saturates to the Q4.28 range.
- R4: When mode_i = 0 (Julia), z starts at the mapped point and c = (c_re_i, c_im_i). When mode_i = 1 (Mandelbrot), both z and c equal the mapped point.
- R5: One iteration produces x' = x² − y² + c_re and y' = 2xy + c_im. Each product drops its low fraction bits by an arithmetic right shift (rounding toward −∞), and x' and y' saturate to Q4.28.
- R6: The squared magnitude is x² + y². It is compared with thresh_i, an unsigned value with 28 fraction bits. In Julia mode a point escapes when the magnitude is ≥ thresh_i. In Mandelbrot mode it escapes only when the magnitude is > thresh_i.
- R7: The escape flag comes from the magnitude of z before an update and is tested before the next update. The first iteration therefore always runs, and one more iteration completes after the z that crosses the threshold.
- R8: The run stops once count + 1 ≥ max_iter_i, using the value captured at start. A limit of 0 or 1 gives a count of 0, and a limit of 128 on a point that never escapes gives 127.
- R9: A run whose count is N raises done_o for exactly one cycle, N + 1 clock edges after the edge that accepts start. busy_o is high from the accepting edge until the edge that raises done_o.
- R10: count_o changes only together with done_o and holds its value between runs.
- R11: A saturated coordinate never wraps to a small value. A point clamped near +8 still escapes at once under a threshold of 4, and it stays clamped under a threshold it cannot reach.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| mode_i | input | 1 | 0 = Julia, 1 = Mandelbrot |
| row_i | input | PW | Pixel row index (real axis) |
| col_i | input | PW | Pixel column index (imaginary axis) |
| org_row_i | input | PW | Row index that maps to real 0 |
| org_col_i | input | PW | Column index that maps to imaginary 0 |
| step_i | input | W | Plane distance per pixel, Q4.28 |
| c_re_i | input | W | Julia constant, real part, Q4.28 |
| c_im_i | input | W | Julia constant, imaginary part, Q4.28 |
| max_iter_i | input | CW | Iteration limit |
| thresh_i | input | W+4 | Escape threshold on x²+y², unsigned, 28 fraction bits |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| count_o | output | CW | Iterations completed in the last run |

## Verification
The bench targets the threshold boundary, where a magnitude of exactly 4 escapes in Julia mode but not in Mandelbrot mode. A design with the comparisons swapped would report 2 instead of 1 in one mode and 1 instead of 2 in the other. It also targets the one-step lag of the escape test: a point whose second z is the first outside the circle must give 2. An engine that tested the updated z would give 1, and one that tested before the first step would give 0. Limits of 0, 1, 2 and 128 catch off-by-one errors in the stop rule. A saturated start point catches wrap-around, which would turn a huge coordinate into a small one and change the count. A start strobe in the middle of a run would restart a design that ignored the busy state, and the count and the done timing would both shift.

// File: rtl/fe_pkg.sv
`timescale 1ns/1ps
package fe_pkg;

  typedef enum logic {
    FE_JULIA  = 1'b0,
    FE_MANDEL = 1'b1
  } fe_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } fe_state_e;

endpackage

// File: rtl/fe_coord_map.sv
`timescale 1ns/1ps
module fe_coord_map #(
  parameter int W  = 32,
  parameter int PW = 16
)(
  input  logic [PW-1:0]        row_i,
  input  logic [PW-1:0]        col_i,
  input  logic [PW-1:0]        org_row_i,
  input  logic [PW-1:0]        org_col_i,
  input  logic signed [W-1:0]  step_i,
  output logic signed [W-1:0]  re_o,
  output logic signed [W-1:0]  im_o
);
  localparam int DW  = PW + 1;
  localparam int PRW = DW + W;
  localparam logic signed [PRW-1:0] HI = {{(PRW-W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [PRW-1:0] LO = ~HI;

  // signed index offset times step, clamped to the coordinate range
  function automatic logic signed [W-1:0] scale(
    input logic [PW-1:0]       idx,
    input logic [PW-1:0]       org,
    input logic signed [W-1:0] stp
  );
    logic signed [DW-1:0]  d;
    logic signed [PRW-1:0] p;
    d = $signed({1'b0, idx}) - $signed({1'b0, org});
    p = PRW'(d) * PRW'(stp);
    if (p > HI)      return HI[W-1:0];
    else if (p < LO) return LO[W-1:0];
    else             return p[W-1:0];
  endfunction

  always_comb begin
    re_o = scale(row_i, org_row_i, step_i);
    im_o = scale(col_i, org_col_i, step_i);
  end
endmodule

// File: rtl/fe_iter_step.sv
`timescale 1ns/1ps
module fe_iter_step #(
  parameter int W    = 32,
  parameter int FRAC = 28
)(
  input  logic signed [W-1:0]    x_i,
  input  logic signed [W-1:0]    y_i,
  input  logic signed [W-1:0]    cr_i,
  input  logic signed [W-1:0]    ci_i,
  output logic signed [2*W-1:0]  mag_o,
  output logic signed [W-1:0]    x_nx_o,
  output logic signed [W-1:0]    y_nx_o
);
  localparam int EW = 2 * W;
  localparam logic signed [EW-1:0] HI = {{(W+1){1'b0}}, {(W-1){1'b1}}};
  localparam logic signed [EW-1:0] LO = ~HI;

  // full product, then drop sh fraction bits (floor)
  function automatic logic signed [EW-1:0] fx_mul(
    input logic signed [W-1:0] a,
    input logic signed [W-1:0] b,
    input int                  sh
  );
    logic signed [EW-1:0] p;
    p = EW'(a) * EW'(b);
    return p >>> sh;
  endfunction

  function automatic logic signed [W-1:0] clamp(input logic signed [EW-1:0] v);
    if (v > HI)      return HI[W-1:0];
    else if (v < LO) return LO[W-1:0];
    else             return v[W-1:0];
  endfunction

  logic signed [EW-1:0] sq_x, sq_y, twice_xy;

  always_comb begin
    sq_x     = fx_mul(x_i, x_i, FRAC);
    sq_y     = fx_mul(y_i, y_i, FRAC);
    twice_xy = fx_mul(x_i, y_i, FRAC - 1);
    mag_o    = sq_x + sq_y;
    x_nx_o   = clamp(sq_x - sq_y + EW'(cr_i));
    y_nx_o   = clamp(twice_xy + EW'(ci_i));
  end
endmodule

// File: rtl/fe_engine.sv
`timescale 1ns/1ps
module fe_engine
  import fe_pkg::*;
#(
  parameter int W    = 32,
  parameter int FRAC = 28,
  parameter int CW   = 8,
  parameter int PW   = 16
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          mode_i,
  input  logic [PW-1:0] row_i,
  input  logic [PW-1:0] col_i,
  input  logic [PW-1:0] org_row_i,
  input  logic [PW-1:0] org_col_i,
  input  logic [W-1:0]  step_i,
  input  logic [W-1:0]  c_re_i,
  input  logic [W-1:0]  c_im_i,
  input  logic [CW-1:0] max_iter_i,
  input  logic [W+3:0]  thresh_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [CW-1:0] count_o
);
  localparam int TW = W + 4;
  localparam int EW = 2 * W;

  fe_state_e            state;
  logic signed [W-1:0]  zx, zy, kx, ky;
  logic [CW-1:0]        cnt, lim, count_q;
  logic [TW-1:0]        thr;
  fe_mode_e             run_mode;
  logic                 esc_q, done_q;

  logic signed [W-1:0]  map_re, map_im, x_nx, y_nx;
  logic signed [EW-1:0] mag, thr_ext;

  // named events used by the checker
  logic accept_w, at_limit_w, stop_w, adv_w, esc_now_w;

  fe_coord_map #(.W(W), .PW(PW)) u_map (
    .row_i     (row_i),
    .col_i     (col_i),
    .org_row_i (org_row_i),
    .org_col_i (org_col_i),
    .step_i    ($signed(step_i)),
    .re_o      (map_re),
    .im_o      (map_im)
  );

  fe_iter_step #(.W(W), .FRAC(FRAC)) u_step (
    .x_i    (zx),
    .y_i    (zy),
    .cr_i   (kx),
    .ci_i   (ky),
    .mag_o  (mag),
    .x_nx_o (x_nx),
    .y_nx_o (y_nx)
  );

  always_comb begin
    thr_ext    = $signed(EW'(thr));
    esc_now_w  = (run_mode == FE_MANDEL) ? (mag > thr_ext) : (mag >= thr_ext);
    accept_w   = start_i && (state == ST_IDLE);
    at_limit_w = ({1'b0, cnt} + (CW+1)'(1)) >= {1'b0, lim};
    stop_w     = (state == ST_RUN) && (at_limit_w || esc_q);
    adv_w      = (state == ST_RUN) && !stop_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      zx       <= '0;
      zy       <= '0;
      kx       <= '0;
      ky       <= '0;
      cnt      <= '0;
      lim      <= '0;
      thr      <= '0;
      run_mode <= FE_JULIA;
      esc_q    <= 1'b0;
      done_q   <= 1'b0;
      count_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept_w) begin
        state    <= ST_RUN;
        zx       <= map_re;
        zy       <= map_im;
        kx       <= (fe_mode_e'(mode_i) == FE_MANDEL) ? map_re : $signed(c_re_i);
        ky       <= (fe_mode_e'(mode_i) == FE_MANDEL) ? map_im : $signed(c_im_i);
        cnt      <= '0;
        lim      <= max_iter_i;
        thr      <= thresh_i;
        run_mode <= fe_mode_e'(mode_i);
        esc_q    <= 1'b0;
      end else if (stop_w) begin
        state   <= ST_IDLE;
        done_q  <= 1'b1;
        count_q <= cnt;
      end else if (adv_w) begin
        zx    <= x_nx;
        zy    <= y_nx;
        cnt   <= cnt + 1'b1;
        esc_q <= esc_now_w;
      end
    end
  end

  assign busy_o  = (state == ST_RUN);
  assign done_o  = done_q;
  assign count_o = count_q;
endmodule

// File: rtl/fe_engine_chk.sv
`timescale 1ns/1ps
module fe_engine_chk #(
  parameter int CW = 8
)(
  input logic          clk,
  input logic          rst_n,
  input logic          busy_o,
  input logic          done_o,
  input logic [CW-1:0] count_o,
  input logic          accept_w,
  input logic          stop_w,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] lim
);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R9
  done_ends_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> busy_o);

  // R2
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !stop_w) |=> (busy_o && cnt == $past(cnt) + 1'b1));

  // R8
  limit_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && (({1'b0, cnt} + (CW+1)'(1)) >= {1'b0, lim})) |=> (!busy_o && done_o));

  // R10
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(count_o));
endmodule

bind fe_engine fe_engine_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .count_o  (count_o),
  .accept_w (accept_w),
  .stop_w   (stop_w),
  .cnt      (cnt),
  .lim      (lim)
);

// File: tb/sim_fe_engine.sv
`timescale 1ns/1ps
module sim_fe_engine;
  localparam int W = 32, CW = 8, PW = 16;
  localparam longint ONE = 64'sd1 << 28;

  logic          clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, mode_i = 1'b0;
  logic [PW-1:0] row_i = '0, col_i = '0, org_row_i = '0, org_col_i = '0;
  logic [W-1:0]  step_i = '0, c_re_i = '0, c_im_i = '0;
  logic [CW-1:0] max_iter_i = '0;
  logic [W+3:0]  thresh_i = '0;
  logic          busy_o, done_o;
  logic [CW-1:0] count_o;

  int checks = 0, errors = 0, cyc = 0;
  string cur_req = "R1";

  // behavioural model state
  bit     m_busy = 0, m_done = 0, live = 0;
  int     m_left = 0, m_res = 0, m_count = 0;

  fe_engine u0 (.*);

  always #2.5 clk = ~clk;

  function automatic longint sat32(longint v);
    if (v > 64'sd2147483647)  return 64'sd2147483647;
    if (v < -64'sd2147483648) return -64'sd2147483648;
    return v;
  endfunction

  function automatic int ref_count(bit md, int r, int c, int orr, int oc, longint stp,
                                   longint cre, longint cim, int mx, longint th);
    longint x, y, kr, ki, xx, yy, xy, mag;
    int n;
    bit esc;
    x = sat32(longint'(r - orr) * stp);
    y = sat32(longint'(c - oc) * stp);
    kr = md ? x : cre;
    ki = md ? y : cim;
    n = 0; esc = 0;
    while (!((n + 1 >= mx) || esc)) begin
      xx  = (x * x) >>> 28;
      yy  = (y * y) >>> 28;
      xy  = (x * y) >>> 27;
      mag = xx + yy;
      esc = md ? (mag > th) : (mag >= th);
      x = sat32(xx - yy + kr);
      y = sat32(xy + ki);
      n++;
    end
    return n;
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // cycle model, advanced on every rising edge
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_count = 0; m_left = 0;
    end else if (m_busy) begin
      if (m_left == 0) begin
        m_busy = 0; m_done = 1; m_count = m_res;
      end else begin
        m_left--; m_done = 0;
      end
    end else begin
      m_done = 0;
      if (start_i) begin
        m_res = ref_count(mode_i, int'(row_i), int'(col_i), int'(org_row_i), int'(org_col_i),
                          longint'($signed(step_i)), longint'($signed(c_re_i)),
                          longint'($signed(c_im_i)), int'(max_iter_i), longint'(thresh_i));
        m_busy = 1; m_left = m_res;
      end
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL R9 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && live) begin
      check(busy_o == m_busy, {cur_req, "/R9 busy"}, busy_o, m_busy);
      check(done_o == m_done, {cur_req, "/R9 done"}, done_o, m_done);
      check(count_o == m_count, {cur_req, "/R10 count"}, count_o, m_count);
    end
  end

  task automatic run(bit md, int r, int c, int orr, int oc, longint stp,
                     longint cre, longint cim, int mx, longint th);
    @(negedge clk);
    mode_i = md; row_i = PW'(r); col_i = PW'(c); org_row_i = PW'(orr); org_col_i = PW'(oc);
    step_i = W'(stp); c_re_i = W'(cre); c_im_i = W'(cim);
    max_iter_i = CW'(mx); thresh_i = (W+4)'(th);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check(busy_o == 0 && done_o == 0 && count_o == 0, "R1", {busy_o, done_o, count_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy_o == 0 && done_o == 0 && count_o == 0, "R1", {busy_o, done_o, count_o}, 0);
    live = 1;

    // R6 boundary magnitude exactly 4
    cur_req = "R6";
    run(0, 2, 0, 0, 0, ONE, 0, 0, 128, 4 * ONE);
    check(count_o == 1, "R6 julia >=", count_o, 1);
    run(1, 2, 0, 0, 0, ONE, 0, 0, 128, 4 * ONE);
    check(count_o == 2, "R6 mandel >", count_o, 2);

    // R3 / R7: offset mapping and one-step lag of the escape test
    cur_req = "R3";
    run(0, 5, 0, 3, 0, 3 * ONE / 4, 0, 0, 128, 4 * ONE);
    check(count_o == 2, "R3 R7 positive offset", count_o, 2);
    run(0, 1, 0, 3, 0, 3 * ONE / 4, 0, 0, 128, 4 * ONE);
    check(count_o == 2, "R3 negative offset", count_o, 2);
    cur_req = "R7";
    run(0, 2, 2, 0, 0, 3 * ONE / 4, 0, 0, 128, 4 * ONE);
    check(count_o == 1, "R7 first step always runs", count_o, 1);

    // R8 limits
    cur_req = "R8";
    run(0, 0, 0, 0, 0, ONE, 0, 0, 128, 4 * ONE);
    check(count_o == 127, "R8 limit 128", count_o, 127);
    run(0, 0, 0, 0, 0, ONE, 0, 0, 0, 4 * ONE);
    check(count_o == 0, "R8 limit 0", count_o, 0);
    run(0, 0, 0, 0, 0, ONE, 0, 0, 1, 4 * ONE);
    check(count_o == 0, "R8 limit 1", count_o, 0);
    run(0, 0, 0, 0, 0, ONE, 0, 0, 2, 4 * ONE);
    check(count_o == 1, "R8 limit 2", count_o, 1);

    // R11 saturation
    cur_req = "R11";
    run(0, 100, 0, 0, 0, 64'sh7FFF_FFFF, 0, 0, 128, 4 * ONE);
    check(count_o == 1, "R11 clamped escapes", count_o, 1);
    run(1, 100, 0, 0, 0, 64'sh7FFF_FFFF, 0, 0, 20, 64'hF_FFFF_FFFF);
    check(count_o == 19, "R11 clamped stays", count_o, 19);

    // R2 start while busy has no effect
    cur_req = "R2";
    @(negedge clk);
    mode_i = 0; row_i = 0; col_i = 0; org_row_i = 0; org_col_i = 0;
    step_i = W'(ONE); c_re_i = 0; c_im_i = 0; max_iter_i = 60; thresh_i = (W+4)'(4 * ONE);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (5) @(negedge clk);
    max_iter_i = 2; row_i = 2;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (!done_o) @(negedge clk);
    check(count_o == 59, "R2 mid-run start ignored", count_o, 59);

    // R4 / R5 scans
    cur_req = "R4";
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 6; c++) begin
        run(1, r, c, 3, 3, ONE / 2, 0, 0, 40, 16 * ONE);
        check(count_o == ref_count(1, r, c, 3, 3, ONE / 2, 0, 0, 40, 16 * ONE),
              "R4 mandel scan", count_o, ref_count(1, r, c, 3, 3, ONE / 2, 0, 0, 40, 16 * ONE));
      end
    cur_req = "R5";
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 6; c++) begin
        run(0, r, c, 3, 3, ONE / 3, longint'(0.285 * 268435456.0),
            longint'(0.01 * 268435456.0), 64, 4 * ONE);
        check(count_o == ref_count(0, r, c, 3, 3, ONE / 3, longint'(0.285 * 268435456.0),
                                   longint'(0.01 * 268435456.0), 64, 4 * ONE),
              "R5 julia scan", count_o,
              ref_count(0, r, c, 3, 3, ONE / 3, longint'(0.285 * 268435456.0),
                        longint'(0.01 * 268435456.0), 64, 4 * ONE));
      end

    // R10 count holds while idle
    cur_req = "R10";
    repeat (4) @(negedge clk);
    check(count_o == m_count, "R10 idle hold", count_o, m_count);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule